// File: doc/BRIEF.md
# Integer Execute Unit with Word-Address Check

This block is the execute stage of a 32-bit integer pipeline. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift count and a 4-bit operation code. It computes one result from this set: wrapping add, add with immediate, bitwise and/or/nor, signed set-less-than, logical shifts, and load-upper-immediate. For load and store it forms the memory byte address and raises a flag when a word access is not aligned to four bytes.

Immediates are widened inside the unit. Add, set-less-than and address forms sign-extend the immediate. Bitwise forms zero-extend it. The upper-immediate form places it in the high half. An equality flag comparing the two register operands is produced every cycle for the branch logic.

All outputs are registered and appear one clock after the inputs. The register file, data memory and branch target logic sit outside this block.

Top module: `exu_core`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `result`, `equal` and `misalign` are all zero.
- R2: Code 0 (add) gives `src_a + src_b` and code 1 (add immediate) gives `src_a` plus the sign-extended `imm`; both wrap modulo 2^32 with no trap.
- R3: Code 2 gives `src_a & src_b` and code 4 gives `src_a | src_b`; code 3 and code 5 apply and/or with `imm` zero-extended to 32 bits.
- R4: Code 6 gives `~(src_a | src_b)`, so a zero `src_b` yields the one's complement of `src_a`.
- R5: Code 7 gives 1 when `src_a` is less than `src_b` and code 8 gives 1 when `src_a` is less than the sign-extended `imm`, both compared as signed two's-complement, and 0 otherwise. Bits 31:1 are zero.
- R6: Code 9 shifts `src_b` left and code 10 shifts it right by `shamt` (0 to 31) places, filling vacated bits with zeros (no rotation).
- R7: Code 11 gives `imm` in bits 31:16 and zeros in bits 15:0.
- R8: Code 12 (load) and code 13 (store) give the byte address `src_a` plus the sign-extended `imm` on `result`.
- R9: `misalign` is 1 only for codes 12 and 13 when the address bits 1:0 are not both zero; for every other code it is 0.
- R10: `equal` is 1 exactly when `src_a == src_b`, whatever the code.
- R11: Every output reflects the inputs sampled at the previous rising clock edge and holds until the next edge.
- R12: Codes 14 and 15 give a `result` of 0 and `misalign` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First register operand, base for addresses |
| src_b | input | 32 | Second register operand, shift source |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| result | output | 32 | Registered result or address |
| equal | output | 1 | Registered operand equality flag |
| misalign | output | 1 | Registered word-alignment error |

## Verification
The bench checks that add with an immediate of 0xFFFF subtracts one. A unit that zero-extends would add 65535 instead. It checks that and/or immediates keep the upper half clear, which sign extension would fill with ones. Set-less-than is run with operands of opposite sign, where an unsigned compare gives the inverse answer. Shifts by 31 are run on a value with both end bits set, where a rotating shifter would leave a stray one. For addresses it uses a negative offset that crosses down through a page boundary. It also uses an odd sum from a plain add, which must not raise the alignment flag. A decoder that tested the base register rather than the sum would misreport the store with offset 2.

// File: rtl/exu_pkg.sv
package exu_pkg;
    parameter int XLEN    = 32;
    parameter int IMM_W   = 16;
    parameter int SH_W    = 5;
    parameter int OP_W    = 4;
    parameter int WORD_BY = 4;
    localparam int ALIGN_W = $clog2(WORD_BY);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDI = 4'd1,
        OP_AND  = 4'd2,
        OP_ANDI = 4'd3,
        OP_OR   = 4'd4,
        OP_ORI  = 4'd5,
        OP_NOR  = 4'd6,
        OP_SLT  = 4'd7,
        OP_SLTI = 4'd8,
        OP_SLL  = 4'd9,
        OP_SRL  = 4'd10,
        OP_LUI  = 4'd11,
        OP_LDW  = 4'd12,
        OP_STW  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            equal;
        logic            misalign;
    } exu_out_t;
endpackage

// File: rtl/exu_immext.sv
module exu_immext #(
    parameter int IMM_W = 16,
    parameter int XLEN  = 32
) (
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  imm_sext,
    output logic [XLEN-1:0]  imm_zext,
    output logic [XLEN-1:0]  imm_upper
);
    localparam int PAD_W = XLEN - IMM_W;

    always_comb begin
        imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_zext  = {{PAD_W{1'b0}}, imm};
        imm_upper = {imm, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int XLEN = 32,
    parameter int SH_W = 5
) (
    input  logic [XLEN-1:0] value,
    input  logic [SH_W-1:0] amount,
    output logic [XLEN-1:0] shl,
    output logic [XLEN-1:0] shr
);
    logic [XLEN-1:0] lstage [0:SH_W];
    logic [XLEN-1:0] rstage [0:SH_W];

    assign lstage[0] = value;
    assign rstage[0] = value;

    // Logarithmic stages: stage k moves by 2^k places when amount[k] is set
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign lstage[k+1] = amount[k] ? {lstage[k][XLEN-1-DIST:0], {DIST{1'b0}}}
                                       : lstage[k];
        assign rstage[k+1] = amount[k] ? {{DIST{1'b0}}, rstage[k][XLEN-1:DIST]}
                                       : rstage[k];
    end

    assign shl = lstage[SH_W];
    assign shr = rstage[SH_W];
endmodule

// File: rtl/exu_compare.sv
module exu_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs_reg,
    input  logic [XLEN-1:0] rhs_imm,
    output logic            same,
    output logic            lt_reg,
    output logic            lt_imm
);
    always_comb begin
        same   = (lhs == rhs_reg);
        lt_reg = $signed(lhs) < $signed(rhs_reg);
        lt_imm = $signed(lhs) < $signed(rhs_imm);
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_sel,
    input  logic [XLEN-1:0]     src_a,
    input  logic [XLEN-1:0]     src_b,
    input  logic [IMM_W-1:0]    imm,
    input  logic [SH_W-1:0]     shamt,
    output logic [XLEN-1:0]     result,
    output logic                equal,
    output logic                misalign
);
    logic [XLEN-1:0] imm_sext, imm_zext, imm_upper;
    logic [XLEN-1:0] shl_val, shr_val;
    logic            same, lt_reg, lt_imm;
    logic [XLEN-1:0] addr;
    exu_out_t        out_d, out_q;
    op_e             op;

    exu_immext #(.IMM_W(IMM_W), .XLEN(XLEN)) u_immext (
        .imm       (imm),
        .imm_sext  (imm_sext),
        .imm_zext  (imm_zext),
        .imm_upper (imm_upper)
    );

    exu_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shifter (
        .value  (src_b),
        .amount (shamt),
        .shl    (shl_val),
        .shr    (shr_val)
    );

    exu_compare #(.XLEN(XLEN)) u_compare (
        .lhs     (src_a),
        .rhs_reg (src_b),
        .rhs_imm (imm_sext),
        .same    (same),
        .lt_reg  (lt_reg),
        .lt_imm  (lt_imm)
    );

    assign op   = op_e'(op_sel);
    assign addr = src_a + imm_sext;

    always_comb begin
        out_d          = '0;
        out_d.equal    = same;
        unique case (op)
            OP_ADD:  out_d.result = src_a + src_b;
            OP_ADDI: out_d.result = src_a + imm_sext;
            OP_AND:  out_d.result = src_a & src_b;
            OP_ANDI: out_d.result = src_a & imm_zext;
            OP_OR:   out_d.result = src_a | src_b;
            OP_ORI:  out_d.result = src_a | imm_zext;
            OP_NOR:  out_d.result = ~(src_a | src_b);
            OP_SLT:  out_d.result = {{(XLEN-1){1'b0}}, lt_reg};
            OP_SLTI: out_d.result = {{(XLEN-1){1'b0}}, lt_imm};
            OP_SLL:  out_d.result = shl_val;
            OP_SRL:  out_d.result = shr_val;
            OP_LUI:  out_d.result = imm_upper;
            OP_LDW, OP_STW: begin
                out_d.result   = addr;
                out_d.misalign = |addr[ALIGN_W-1:0];
            end
            default: out_d.result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result   = out_q.result;
    assign equal    = out_q.equal;
    assign misalign = out_q.misalign;
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk
    import exu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_sel,
    input logic [XLEN-1:0]  src_a,
    input logic [XLEN-1:0]  src_b,
    input logic [IMM_W-1:0] imm,
    input logic [SH_W-1:0]  shamt,
    input logic [XLEN-1:0]  result,
    input logic             equal,
    input logic             misalign
);
    // R9
    nonmem_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 4'd12 && op_sel != 4'd13) |=> !misalign);

    // R7
    upper_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd11) |=> (result[15:0] == 16'h0 && result[31:16] == $past(imm)));

    // R10
    equal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (equal == ($past(src_a) == $past(src_b))));

    // R5
    slt_boolean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd7 || op_sel == 4'd8) |=> (result[XLEN-1:1] == '0));

    // R4
    nor_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd6 && src_b == '0) |=> (result == ~$past(src_a)));

    // R6
    shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 4'd9 || op_sel == 4'd10) && shamt == '0) |=> (result == $past(src_b)));

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd14 || op_sel == 4'd15) |=> (result == '0));
endmodule

bind exu_core exu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm      (imm),
    .shamt    (shamt),
    .result   (result),
    .equal    (equal),
    .misalign (misalign)
);

// File: tb/exu_core_test.sv
module exu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic        mis;
        logic [3:0]  req;
    } vec_t;

    // Columns: op, a, b, imm, shamt, expected result, expected misalign, requirement number
    localparam vec_t VEC [NVEC] = '{
        '{4'd0,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0,  32'h80000000, 1'b0, 4'd2},  // R2 wrap
        '{4'd0,  32'hffffffff, 32'h00000002, 16'h0000, 5'd0,  32'h00000001, 1'b0, 4'd2},  // R2
        '{4'd1,  32'h00000100, 32'h0,        16'hffff, 5'd0,  32'h000000ff, 1'b0, 4'd2},  // R2 sext
        '{4'd3,  32'hffffffff, 32'h0,        16'h8001, 5'd0,  32'h00008001, 1'b0, 4'd3},  // R3 zext
        '{4'd5,  32'h12340000, 32'h0,        16'hffff, 5'd0,  32'h1234ffff, 1'b0, 4'd3},  // R3
        '{4'd2,  32'hf0f0f0f0, 32'hff00ff00, 16'h0000, 5'd0,  32'hf000f000, 1'b0, 4'd3},  // R3
        '{4'd4,  32'hf0f00000, 32'h0000000f, 16'h0000, 5'd0,  32'hf0f0000f, 1'b0, 4'd3},  // R3
        '{4'd6,  32'h12345678, 32'h00000000, 16'h0000, 5'd0,  32'hedcba987, 1'b0, 4'd4},  // R4 not
        '{4'd6,  32'hf0f0f0f0, 32'h0f0f0000, 16'h0000, 5'd0,  32'h00000f0f, 1'b0, 4'd4},  // R4
        '{4'd7,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0,  32'h00000001, 1'b0, 4'd5},  // R5
        '{4'd7,  32'h00000001, 32'hffffffff, 16'h0000, 5'd0,  32'h00000000, 1'b0, 4'd5},  // R5
        '{4'd8,  32'hfffffff0, 32'h0,        16'hfff8, 5'd0,  32'h00000001, 1'b0, 4'd5},  // R5
        '{4'd8,  32'h00000005, 32'h0,        16'h8000, 5'd0,  32'h00000000, 1'b0, 4'd5},  // R5
        '{4'd9,  32'h0,        32'h80000001, 16'h0000, 5'd31, 32'h80000000, 1'b0, 4'd6},  // R6
        '{4'd10, 32'h0,        32'h80000001, 16'h0000, 5'd31, 32'h00000001, 1'b0, 4'd6},  // R6
        '{4'd9,  32'h0,        32'h12345678, 16'h0000, 5'd4,  32'h23456780, 1'b0, 4'd6},  // R6
        '{4'd10, 32'h0,        32'h12345678, 16'h0000, 5'd4,  32'h01234567, 1'b0, 4'd6},  // R6
        '{4'd9,  32'h0,        32'hdeadbeef, 16'h0000, 5'd0,  32'hdeadbeef, 1'b0, 4'd6},  // R6
        '{4'd11, 32'hffffffff, 32'h0,        16'habcd, 5'd0,  32'habcd0000, 1'b0, 4'd7},  // R7
        '{4'd12, 32'h00001000, 32'h0,        16'h0008, 5'd0,  32'h00001008, 1'b0, 4'd8},  // R8
        '{4'd12, 32'h00001000, 32'h0,        16'hfffc, 5'd0,  32'h00000ffc, 1'b0, 4'd8},  // R8
        '{4'd13, 32'h00001000, 32'h0,        16'h0002, 5'd0,  32'h00001002, 1'b1, 4'd9},  // R9
        '{4'd12, 32'h00001003, 32'h0,        16'h0000, 5'd0,  32'h00001003, 1'b1, 4'd9},  // R9
        '{4'd0,  32'h00000001, 32'h00000002, 16'h0000, 5'd0,  32'h00000003, 1'b0, 4'd9},  // R9
        '{4'd14, 32'h00000005, 32'h00000005, 16'h1234, 5'd3,  32'h00000000, 1'b0, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        equal;
    logic        misalign;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exu_core uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .imm(imm), .shamt(shamt), .result(result), .equal(equal), .misalign(misalign)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_sel = v.op; src_a = v.a; src_b = v.b; imm = v.imm; shamt = v.sh;
    endtask

    initial begin
        // R1: outputs zero while reset is held, even with live inputs
        src_a = 32'h5; src_b = 32'h5; op_sel = 4'd13; imm = 16'h1;
        repeat (3) @(negedge clk);
        check("R1 result", result, 32'h0);
        check("R1 equal", {31'h0, equal}, 32'h0);
        check("R1 misalign", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d result", VEC[i].req, i), result, VEC[i].exp);
            check($sformatf("R%0d vec %0d misalign", VEC[i].req, i), {31'h0, misalign}, {31'h0, VEC[i].mis});
            // R10: equality flag follows the operands on every vector
            check($sformatf("R10 vec %0d equal", i), {31'h0, equal}, {31'h0, VEC[i].a == VEC[i].b});
        end

        // R11: new inputs do not show until the next rising edge
        drive('{4'd0, 32'h00000010, 32'h00000020, 16'h0, 5'd0, 32'h0, 1'b0, 4'd0});
        @(negedge clk);
        drive('{4'd0, 32'h00000001, 32'h00000001, 16'h0, 5'd0, 32'h0, 1'b0, 4'd0});
        #1;
        check("R11 hold before edge", result, 32'h00000030);
        @(negedge clk);
        check("R11 update after edge", result, 32'h00000002);

        // R12: second reserved code, with an unaligned-looking sum
        drive('{4'd15, 32'h00000003, 32'h0, 16'h0001, 5'd0, 32'h0, 1'b0, 4'd0});
        @(negedge clk);
        check("R12 code 15 result", result, 32'h0);
        check("R12 code 15 misalign", {31'h0, misalign}, 32'h0);

        // R1: reset asserted mid-run clears a pending misaligned store
        drive('{4'd13, 32'h00000001, 32'h00000001, 16'h0, 5'd0, 32'h0, 1'b0, 4'd0});
        @(negedge clk);
        check("R9 store base 1", {31'h0, misalign}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run result", result, 32'h0);
        check("R1 mid-run misalign", {31'h0, misalign}, 32'h0);
        check("R1 mid-run equal", {31'h0, equal}, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule